// File: doc/BRIEF.md
# Prescaled Interval Timer

This block is an 8-bit interval timer that counts down. Software loads it with one register write. The written byte is the start value. The address bits of that same write choose the prescale rate and the interrupt enable. Inside, the block keeps a wide two's-complement count that drops by one on every cycle in which the system clock enable is high.

A timer read divides that count back down by the chosen prescale, so the visible value falls once per prescale period. When the count passes below zero, the timer has expired. From then on a timer read returns the raw low byte of the count, which falls once per enabled cycle, as if the prescaler were bypassed. The count then keeps wrapping.

An expiry flag can be read at any time. A sticky "triggered" flag is updated by timer reads. The interrupt request is the triggered flag gated by the interrupt enable. At reset the timer is never zero: it starts from a nonzero parameter value at the slowest rate.

Top module: `pit_timer`

## Requirements
- R1: A write is a load when `sel`, `wr_en`, `addr[2]` and `addr[4]` are all 1. A load sets the count to `wdata` shifted left by the amount that `addr[1:0]` selects: 0 gives a shift of 0, 1 gives 3, 2 gives 6 and 3 gives 10. The count is then read at that rate.
- R2: On a load, `addr[3]` becomes the interrupt enable.
- R3: When no load occurs, the count decreases by one in each cycle with `tick_en` high and holds in every other cycle.
- R4: A timer read is `sel`, `rd_en` and `addr[2]` high with `addr[0]` low. While bit 18 of the count is clear, it returns bits [7:0] of the count shifted right by the selected amount.
- R5: While bit 18 of the count is set (expired), a timer read returns count[7:0]. The count keeps falling by one per enabled cycle, whatever the rate.
- R6: A flag read is `sel`, `rd_en`, `addr[2]` and `addr[0]` high. It returns 0x80 when the count is negative and 0x00 otherwise.
- R7: A load clears the triggered flag. Without a load, a timer read sets the flag when the count is expired and is not all ones (-1), and clears it otherwise.
- R8: `irq` is high exactly when both the interrupt enable and the triggered flag are set.
- R9: A write without both `addr[2]` and `addr[4]` high, or with `sel` low, changes nothing.
- R10: After reset the count is `RST_VAL` shifted left by 10, the rate is divide-by-1024, and the enable and triggered flags are clear.
- R11: `rdata` is 0x00 in every cycle without a timer read or flag read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count enable, one count step per high cycle |
| sel | input | 1 | Register window select |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 5 | Register address; also carries the rate and enable on loads |
| wdata | input | 8 | Write data (start value) |
| rdata | output | 8 | Read data, combinational from the current state |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with `CW` = 19 and `RST_VAL` = 3. The short reset value makes the first expiry at the divide-by-1024 rate fall within about 3000 cycles, so the reset state, the slow rate and the switch to post-expiry reads are all covered in one run. Loads with small start values at each of the four rates reach expiry quickly. The exact -1 cycle, where a timer read must leave the triggered flag clear, is reached by a counted run of ticks. A pseudo-random `tick_en` pattern shows that counting follows the enable and not the clock.

// File: rtl/pit_pkg.sv
package pit_pkg;

  // Decoded access kinds for one cycle.
  typedef struct packed {
    logic load;
    logic rd_timer;
    logic rd_flag;
  } pit_access_t;

  // Shift amount for a prescale selector.
  function automatic logic [3:0] rate_shift(input logic [1:0] rate);
    case (rate)
      2'd0:    rate_shift = 4'd0;
      2'd1:    rate_shift = 4'd3;
      2'd2:    rate_shift = 4'd6;
      default: rate_shift = 4'd10;
    endcase
  endfunction

endpackage

// File: rtl/pit_decode.sv
module pit_decode
  import pit_pkg::*;
(
  input  logic        sel,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [4:0]  addr,
  output pit_access_t acc
);
  logic in_timer_space;
  assign in_timer_space = sel & addr[2];

  always_comb begin
    acc.load     = in_timer_space & wr_en & addr[4];
    acc.rd_timer = in_timer_space & rd_en & ~addr[0];
    acc.rd_flag  = in_timer_space & rd_en & addr[0];
  end
endmodule

// File: rtl/pit_counter.sv
module pit_counter
  import pit_pkg::*;
#(
  parameter int          CW      = 19,
  parameter logic [7:0]  RST_VAL = 8'hFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          load,
  input  logic [1:0]    rate_in,
  input  logic [7:0]    wdata,
  output logic [CW-1:0] count,
  output logic [1:0]    rate_q
);
  localparam logic [1:0] RST_RATE = 2'd3;

  function automatic logic [CW-1:0] scaled(input logic [7:0] v, input logic [1:0] r);
    scaled = CW'(v) << rate_shift(r);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count  <= scaled(RST_VAL, RST_RATE);
      rate_q <= RST_RATE;
    end else if (load) begin
      count  <= scaled(wdata, rate_in);
      rate_q <= rate_in;
    end else if (tick_en) begin
      count  <= count - 1'b1;
    end
  end
endmodule

// File: rtl/pit_flags.sv
module pit_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic ien_in,
  input  logic rd_timer,
  input  logic expired,
  input  logic at_minus_one,
  output logic ien,
  output logic trig
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien  <= 1'b0;
      trig <= 1'b0;
    end else if (load) begin
      ien  <= ien_in;
      trig <= 1'b0;
    end else if (rd_timer) begin
      trig <= expired & ~at_minus_one;
    end
  end
endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
#(
  parameter int         CW      = 19,
  parameter logic [7:0] RST_VAL = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       sel,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [4:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       irq
);
  localparam int EXP_BIT = 18;

  pit_access_t   acc;
  logic          load_ev, rdt_ev, rdf_ev;
  logic [CW-1:0] count;
  logic [1:0]    rate_q;
  logic          expired, negative, at_minus_one;
  logic          ien, trig;

  pit_decode u_dec (
    .sel(sel), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .acc(acc)
  );

  assign load_ev = acc.load;
  assign rdt_ev  = acc.rd_timer;
  assign rdf_ev  = acc.rd_flag;

  pit_counter #(.CW(CW), .RST_VAL(RST_VAL)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .load(load_ev),
    .rate_in(addr[1:0]), .wdata(wdata), .count(count), .rate_q(rate_q)
  );

  assign expired      = count[EXP_BIT];
  assign negative     = count[CW-1];
  assign at_minus_one = &count;

  pit_flags u_flg (
    .clk(clk), .rst_n(rst_n), .load(load_ev), .ien_in(addr[3]),
    .rd_timer(rdt_ev), .expired(expired), .at_minus_one(at_minus_one),
    .ien(ien), .trig(trig)
  );

  // Visible timer byte: prescaled before expiry, raw low byte after.
  function automatic logic [7:0] timer_view(input logic [CW-1:0] c,
                                            input logic [1:0] r,
                                            input logic ex);
    logic [CW-1:0] shifted;
    shifted = c >> rate_shift(r);
    timer_view = ex ? c[7:0] : shifted[7:0];
  endfunction

  always_comb begin
    rdata = 8'h00;
    if (rdt_ev)      rdata = timer_view(count, rate_q, expired);
    else if (rdf_ev) rdata = {negative, 7'b0};
  end

  assign irq = ien & trig;
endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk #(
  parameter int CW = 19
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_en,
  input logic [4:0]    addr,
  input logic [7:0]    wdata,
  input logic [7:0]    rdata,
  input logic          irq,
  input logic          load_ev,
  input logic          rdt_ev,
  input logic          rdf_ev,
  input logic [CW-1:0] count,
  input logic          trig
);
  // R1: an unscaled load takes the written byte as the count
  a_r1_load_unscaled: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev && addr[1:0] == 2'd0 |=> count == CW'($past(wdata)));

  // R3: counting follows the enable
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    !load_ev && tick_en |=> count == $past(count) - 1'b1);
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_ev && !tick_en |=> $stable(count));

  // R7: a load clears the triggered flag
  a_r7_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> !trig);

  // R2 / R8: a load without enable leaves no request
  a_r2_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev && !addr[3] |=> !irq);

  // R6: the flag read has only two values
  a_r6_flag_values: assert property (@(posedge clk) disable iff (!rst_n)
    rdf_ev |-> (rdata == 8'h00 || rdata == 8'h80));

  // R11: idle read bus
  a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rdt_ev && !rdf_ev |-> rdata == 8'h00);
endmodule

bind pit_timer pit_timer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .addr(addr), .wdata(wdata),
  .rdata(rdata), .irq(irq), .load_ev(load_ev), .rdt_ev(rdt_ev),
  .rdf_ev(rdf_ev), .count(count), .trig(trig)
);

// File: tb/sim_pit_timer.sv
`timescale 1ns/1ps
module sim_pit_timer;
  localparam int MOD  = 1 << 19;
  localparam int HALF = 1 << 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0, sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq;

  int checks = 0, failures = 0;
  bit done = 0;

  // reference state
  int m_cnt, m_div;
  bit m_ien, m_trig;
  logic [15:0] lf = 16'hACE1;

  always #10 clk = ~clk;

  pit_timer #(.CW(19), .RST_VAL(8'd3)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .sel(sel), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  function automatic int div_of(input logic [1:0] r);
    case (r)
      2'd0: return 1;
      2'd1: return 8;
      2'd2: return 64;
      default: return 1024;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: drive at the falling edge, compare, then advance the model.
  task automatic step(input logic s, input logic w, input logic r,
                      input logic [4:0] a, input logic [7:0] d, input logic t);
    int exp_rd;
    string tag;
    bit ld;
    sel = s; wr_en = w; rd_en = r; addr = a; wdata = d; tick_en = t;
    #1;
    exp_rd = 0;
    tag = "R11";
    if (s && r && a[2]) begin
      if (a[0]) begin
        tag = "R6";
        exp_rd = (m_cnt >= HALF) ? 128 : 0;
      end else if (m_cnt >= HALF) begin
        tag = "R5";
        exp_rd = m_cnt % 256;
      end else begin
        tag = "R4";
        exp_rd = (m_cnt / m_div) % 256;
      end
    end
    check(tag, int'(rdata), exp_rd);
    check("R8", int'(irq), int'(m_ien && m_trig));
    @(posedge clk);
    ld = s && w && a[2] && a[4];
    if (ld) begin                                 // R1 R2 R7
      m_div  = div_of(a[1:0]);
      m_cnt  = (int'(d) * m_div) % MOD;
      m_ien  = a[3];
      m_trig = 0;
    end else begin
      if (s && r && a[2] && !a[0])                // R7
        m_trig = (m_cnt >= HALF) && (m_cnt != MOD - 1);
      if (t) m_cnt = (m_cnt + MOD - 1) % MOD;     // R3
    end
    @(negedge clk);
  endtask

  // Run cycles with mixed read kinds; tick either always or pseudo-random.
  task automatic run(input int n, input bit rnd);
    for (int i = 0; i < n; i++) begin
      logic t;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      t = rnd ? lf[0] : 1'b1;
      case (i % 5)
        0, 2: step(1, 0, 1, 5'b00100, 8'h00, t);  // timer read
        1, 3: step(1, 0, 1, 5'b00101, 8'h00, t);  // flag read
        default: step(0, 0, 0, 5'b00000, 8'h00, t);
      endcase
    end
  endtask

  task automatic load(input logic [1:0] r, input bit en, input logic [7:0] v);
    step(1, 1, 0, {1'b1, en, 1'b1, r}, v, 1'b1);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog R3 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    m_cnt = 3 * 1024; m_div = 1024; m_ien = 0; m_trig = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run(20, 0);
    // R5: run past the first expiry at divide-by-1024
    run(3100, 0);
    step(1, 0, 1, 5'b00100, 8'h00, 1);            // timer read sets triggered
    // R9: writes outside the load decode are ignored
    step(1, 1, 0, 5'b00100, 8'h00, 1);
    step(1, 1, 0, 5'b11000, 8'h00, 1);
    step(0, 1, 0, 5'b11100, 8'h00, 1);
    step(1, 1, 0, 5'b01101, 8'h00, 1);
    run(10, 0);
    // R1 R2: each rate, enable alternating, random ticks
    for (int r = 0; r < 4; r++) begin
      load(r[1:0], r[0], 8'h07);
      run((r == 3) ? 15000 : 1200, 1);
    end
    // R7 R8: exact -1 cycle leaves flag clear, -2 sets it
    load(2'd0, 1'b1, 8'h05);
    repeat (6) step(0, 0, 0, 5'b00000, 8'h00, 1);
    step(1, 0, 1, 5'b00100, 8'h00, 0);            // count -1
    step(1, 0, 1, 5'b00101, 8'h00, 1);
    step(1, 0, 1, 5'b00100, 8'h00, 0);            // count -2
    run(8, 0);
    // R7: load in the same cycle as a timer read wins
    step(1, 1, 1, 5'b11110, 8'h09, 1);
    run(100, 1);
    // R2: reload without enable drops the request
    step(1, 0, 1, 5'b00100, 8'h00, 1);
    load(2'd1, 1'b0, 8'h02);
    run(40, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule